// File: doc/BRIEF.md
# Vectored Interrupt Trap CSR Unit

This block keeps the trap-related control and status registers for machine and supervisor privilege. Each privilege has four registers: a trap-vector register, a cause register, a base register for the general interrupt vector table and a base register for the external interrupt vector table. A CSR port reads and writes these registers by address. A trap-entry strobe names the target privilege. When that strobe is high, the block formats the cause value and writes it into the cause register of that privilege. In the same cycle it drives the handler address for the trap.

The trap-vector register carries a 2-bit mode in its low bits. Mode `11` selects interrupt vector table mode. In that mode an external interrupt packs its 16-bit major identity and its wider minor identity into the exception code. The handler address then comes from one of the two table base registers. In every other case the cause keeps the ordinary layout: an interrupt flag on top and the exception code below it.

The CSR port and the trap strobe are plain single-cycle controls with no back-pressure. The block accepts every request in the cycle it is presented and never stalls either port. The target privilege selects the bank.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset, all eight registers read as zero.
- R2: The CSR addresses are as follows. Machine mode: cause 0x342, trap vector 0x305, interrupt table base 0x307, external table base 0x308. Supervisor mode: cause 0x142, trap vector 0x105, interrupt table base 0x107, external table base 0x108. A read returns data combinationally in the cycle `csr_req` is high. A write (`csr_we`=1) takes effect at that clock edge.
- R3: A request to any other address gives `csr_rdata`=0 and `csr_illegal`=1 in the same cycle. A write to such an address changes no register.
- R4: The mode field of the trap vector is bits 1:0. The values 00, 01 and 11 are stored as written. A write of 10 stores 00. Bits XLEN-1:2 are stored as written.
- R5: A write to either table base register stores the data with its low log2(XLEN/8) bits forced to zero.
- R6: When `trap_valid` is high, the cause register of the target privilege (`trap_priv`: 1 = machine, 0 = supervisor) loads the formatted cause at that edge. The other privilege's cause is unchanged. The trap load wins over a CSR write to the same cause register in the same cycle.
- R7: In table mode (target trap-vector bits 1:0 = 11), an external interrupt gives a cause with the following fields. Bit XLEN-1 = 1. Bits XLEN-2:16 = minor identity (XLEN-17 bits). Bits 15:0 = major identity.
- R8: In all other cases the cause is {`trap_is_irq`, `trap_code`}, with `trap_code` filling bits XLEN-2:0.
- R9: In table mode, an external interrupt drives `handler_pc` = external table base + minor × XLEN/8, in the same cycle as the strobe.
- R10: In table mode, a non-external interrupt drives `handler_pc` = interrupt table base + code × XLEN/8.
- R11: Exceptions in any mode, and interrupts in mode 00, go to the trap-vector base with bits 1:0 cleared. Interrupts in mode 01 go to that base + 4 × code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req | input | 1 | CSR access strobe |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, valid with `csr_req` |
| csr_illegal | output | 1 | Access hit no implemented register |
| trap_valid | input | 1 | Trap-entry strobe |
| trap_priv | input | 1 | Target privilege, 1 = machine, 0 = supervisor |
| trap_is_irq | input | 1 | Trap is an interrupt |
| trap_is_ext | input | 1 | Interrupt is external |
| trap_major | input | 16 | Major interrupt identity |
| trap_minor | input | XLEN-17 | Minor interrupt identity |
| trap_code | input | XLEN-1 | Ordinary exception code |
| handler_pc | output | XLEN | Handler target for the current trap |

## Verification
Three results are combinational: read data and the illegal flag appear in the cycle of the request, and `handler_pc` appears in the cycle of the strobe. The bench therefore compares these outputs one time unit after it drives the inputs, before the next rising edge. Register writes and cause loads land at the edge that ends the request. The bench's reference model updates its own state right after that edge, and later reads see the new value from the next cycle on. Directed cases cover each mode with external and non-external interrupts, exceptions, the reserved mode value, masked table bases, illegal addresses and a trap that collides with a cause write. A random phase then mixes all of these.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;
  localparam logic [7:0] OFF_CAUSE = 8'h42;
  localparam logic [7:0] OFF_TVEC  = 8'h05;
  localparam logic [7:0] OFF_IVT   = 8'h07;
  localparam logic [7:0] OFF_EIVT  = 8'h08;
  localparam logic [3:0] HI_MACH   = 4'h3;
  localparam logic [3:0] HI_SUPV   = 4'h1;
  localparam int unsigned NUM_PRIV = 2;
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_VECTORED = 2'b01,
    MODE_RSVD     = 2'b10,
    MODE_TABLE    = 2'b11
  } tvec_mode_e;
endpackage

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
  import trap_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [3:0] ADDR_HI = HI_MACH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [11:0]     addr,
  input  logic [XLEN-1:0] wdata,
  input  logic            trap_load,
  input  logic [XLEN-1:0] trap_cause,
  output logic [XLEN-1:0] tvec,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] ivt,
  output logic [XLEN-1:0] eivt,
  output logic            hit,
  output logic [XLEN-1:0] rdata
);
  localparam int unsigned ALIGN = $clog2(XLEN / 8);
  localparam logic [XLEN-1:0] BASE_MASK = {{(XLEN - ALIGN){1'b1}}, {ALIGN{1'b0}}};

  logic sel_cause, sel_tvec, sel_ivt, sel_eivt;
  logic [1:0] mode_in;
  logic [XLEN-1:0] tvec_next;

  assign sel_cause = (addr == {ADDR_HI, OFF_CAUSE});
  assign sel_tvec  = (addr == {ADDR_HI, OFF_TVEC});
  assign sel_ivt   = (addr == {ADDR_HI, OFF_IVT});
  assign sel_eivt  = (addr == {ADDR_HI, OFF_EIVT});
  assign hit = sel_cause | sel_tvec | sel_ivt | sel_eivt;

  // reserved mode value is legalised to direct mode
  assign mode_in   = (wdata[1:0] == MODE_RSVD) ? MODE_DIRECT : wdata[1:0];
  assign tvec_next = {wdata[XLEN-1:2], mode_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tvec  <= '0;
      cause <= '0;
      ivt   <= '0;
      eivt  <= '0;
    end else begin
      if (wr_en && sel_tvec) tvec <= tvec_next;
      if (wr_en && sel_ivt)  ivt  <= wdata & BASE_MASK;
      if (wr_en && sel_eivt) eivt <= wdata & BASE_MASK;
      if (trap_load)                  cause <= trap_cause;
      else if (wr_en && sel_cause)    cause <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_cause) rdata = cause;
    if (sel_tvec)  rdata = tvec;
    if (sel_ivt)   rdata = ivt;
    if (sel_eivt)  rdata = eivt;
  end
endmodule

// File: rtl/trap_cause_fmt.sv
module trap_cause_fmt
  import trap_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]       mode,
  input  logic             is_irq,
  input  logic             is_ext,
  input  logic [15:0]      major,
  input  logic [XLEN-18:0] minor,
  input  logic [XLEN-2:0]  code,
  output logic [XLEN-1:0]  cause
);
  logic packed_form;
  assign packed_form = is_irq && is_ext && (mode == MODE_TABLE);

  always_comb begin
    if (packed_form) cause = {1'b1, minor, major};
    else             cause = {is_irq, code};
  end
endmodule

// File: rtl/trap_target_sel.sv
module trap_target_sel
  import trap_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  tvec,
  input  logic [XLEN-1:0]  ivt,
  input  logic [XLEN-1:0]  eivt,
  input  logic             is_irq,
  input  logic             is_ext,
  input  logic [XLEN-18:0] minor,
  input  logic [XLEN-2:0]  code,
  output logic [XLEN-1:0]  target
);
  localparam int unsigned ALIGN = $clog2(XLEN / 8);

  logic [XLEN-1:0] base, minor_off, code_off, vec_off;

  assign base      = {tvec[XLEN-1:2], 2'b00};
  assign minor_off = XLEN'(minor) << ALIGN;
  assign code_off  = XLEN'(code) << ALIGN;
  assign vec_off   = XLEN'(code) << 2;

  always_comb begin
    target = base;
    if (is_irq) begin
      unique case (tvec[1:0])
        MODE_TABLE:    target = is_ext ? (eivt + minor_off) : (ivt + code_off);
        MODE_VECTORED: target = base + vec_off;
        default:       target = base;
      endcase
    end
  end
endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
  import trap_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_req,
  input  logic             csr_we,
  input  logic [11:0]      csr_addr,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             csr_illegal,
  input  logic             trap_valid,
  input  logic             trap_priv,
  input  logic             trap_is_irq,
  input  logic             trap_is_ext,
  input  logic [15:0]      trap_major,
  input  logic [XLEN-18:0] trap_minor,
  input  logic [XLEN-2:0]  trap_code,
  output logic [XLEN-1:0]  handler_pc
);
  logic [XLEN-1:0] tvec_q  [NUM_PRIV];
  logic [XLEN-1:0] cause_q [NUM_PRIV];
  logic [XLEN-1:0] ivt_q   [NUM_PRIV];
  logic [XLEN-1:0] eivt_q  [NUM_PRIV];
  logic [XLEN-1:0] bank_rd [NUM_PRIV];
  logic [NUM_PRIV-1:0] bank_hit;
  logic [XLEN-1:0] fmt_cause;
  logic [XLEN-1:0] sel_tvec, sel_ivt, sel_eivt;
  logic wr_en;

  assign wr_en = csr_req && csr_we;

  // index 1 is machine, index 0 is supervisor
  for (genvar g = 0; g < NUM_PRIV; g++) begin : g_bank
    logic load;
    assign load = trap_valid && (trap_priv == (g == 1));
    trap_csr_bank #(
      .XLEN(XLEN),
      .ADDR_HI((g == 1) ? HI_MACH : HI_SUPV)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(csr_addr),
      .wdata(csr_wdata), .trap_load(load), .trap_cause(fmt_cause),
      .tvec(tvec_q[g]), .cause(cause_q[g]), .ivt(ivt_q[g]), .eivt(eivt_q[g]),
      .hit(bank_hit[g]), .rdata(bank_rd[g])
    );
  end

  assign sel_tvec = trap_priv ? tvec_q[1] : tvec_q[0];
  assign sel_ivt  = trap_priv ? ivt_q[1]  : ivt_q[0];
  assign sel_eivt = trap_priv ? eivt_q[1] : eivt_q[0];

  trap_cause_fmt #(.XLEN(XLEN)) u_fmt (
    .mode(sel_tvec[1:0]), .is_irq(trap_is_irq), .is_ext(trap_is_ext),
    .major(trap_major), .minor(trap_minor), .code(trap_code), .cause(fmt_cause)
  );

  trap_target_sel #(.XLEN(XLEN)) u_tgt (
    .tvec(sel_tvec), .ivt(sel_ivt), .eivt(sel_eivt), .is_irq(trap_is_irq),
    .is_ext(trap_is_ext), .minor(trap_minor), .code(trap_code), .target(handler_pc)
  );

  assign csr_rdata   = csr_req ? (bank_rd[0] | bank_rd[1]) : '0;
  assign csr_illegal = csr_req && (bank_hit == '0);
endmodule

// File: rtl/trap_csr_chk.sv
module trap_csr_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_req,
  input logic            csr_we,
  input logic [11:0]     csr_addr,
  input logic [XLEN-1:0] csr_rdata,
  input logic            csr_illegal,
  input logic            trap_valid,
  input logic            trap_priv,
  input logic            trap_is_irq,
  input logic            trap_is_ext,
  input logic [15:0]     trap_major,
  input logic [XLEN-1:0] fmt_cause,
  input logic [XLEN-1:0] m_tvec,
  input logic [XLEN-1:0] s_tvec,
  input logic [XLEN-1:0] m_cause,
  input logic [XLEN-1:0] s_cause
);
  p_illegal_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));

  p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvec[1:0] != 2'b10) && (s_tvec[1:0] != 2'b10));

  p_cause_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_priv) |=> (m_cause == $past(fmt_cause)));

  p_other_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_priv && !(csr_req && csr_we && csr_addr == 12'h142))
      |=> $stable(s_cause));

  p_major_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_priv && trap_is_irq && trap_is_ext && m_tvec[1:0] == 2'b11)
      |=> (m_cause[15:0] == $past(trap_major)) && m_cause[XLEN-1]);
endmodule

bind trap_csr_unit trap_csr_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
  .csr_addr(csr_addr), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
  .trap_valid(trap_valid), .trap_priv(trap_priv), .trap_is_irq(trap_is_irq),
  .trap_is_ext(trap_is_ext), .trap_major(trap_major), .fmt_cause(fmt_cause),
  .m_tvec(tvec_q[1]), .s_tvec(tvec_q[0]), .m_cause(cause_q[1]), .s_cause(cause_q[0])
);

// File: tb/sim_trap_csr_unit.sv
module sim_trap_csr_unit;
  localparam int XLEN = 32;
  localparam int CLK_P = 10;
  localparam int SCL = XLEN / 8;

  logic clk = 0, rst_n = 0;
  logic csr_req = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0, csr_rdata, handler_pc;
  logic csr_illegal;
  logic trap_valid = 0, trap_priv = 0, trap_is_irq = 0, trap_is_ext = 0;
  logic [15:0] trap_major = '0;
  logic [XLEN-18:0] trap_minor = '0;
  logic [XLEN-2:0] trap_code = '0;

  int total = 0, bad = 0;
  string tag = "R1";

  logic [XLEN-1:0] m_tv[2], m_cs[2], m_iv[2], m_ev[2];

  always #(CLK_P/2) clk = ~clk;

  trap_csr_unit #(.XLEN(XLEN)) u0 (.*);

  function automatic logic [XLEN-1:0] ref_cause();
    logic [1:0] md = m_tv[trap_priv][1:0];
    if (trap_is_irq && trap_is_ext && md == 2'b11) return {1'b1, trap_minor, trap_major};
    return {trap_is_irq, trap_code};
  endfunction

  function automatic logic [XLEN-1:0] ref_pc();
    logic [XLEN-1:0] tv = m_tv[trap_priv];
    logic [XLEN-1:0] base = tv & ~XLEN'(3);
    if (trap_is_irq && tv[1:0] == 2'b11)
      return trap_is_ext ? m_ev[trap_priv] + XLEN'(trap_minor) * SCL
                         : m_iv[trap_priv] + XLEN'(trap_code) * SCL;
    if (trap_is_irq && tv[1:0] == 2'b01) return base + XLEN'(trap_code) * 4;
    return base;
  endfunction

  // returns register index 0..3 (cause,tvec,ivt,eivt) or -1; p gets privilege
  function automatic int decode(input logic [11:0] a, output int p);
    p = (a[11:8] == 4'h3) ? 1 : 0;
    if (a[11:8] != 4'h3 && a[11:8] != 4'h1) return -1;
    case (a[7:0])
      8'h42: return 0;
      8'h05: return 1;
      8'h07: return 2;
      8'h08: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step();
    int p, r;
    logic [XLEN-1:0] ev, c;
    #1;
    if (csr_req) begin
      r = decode(csr_addr, p);
      case (r)
        0: ev = m_cs[p];
        1: ev = m_tv[p];
        2: ev = m_iv[p];
        3: ev = m_ev[p];
        default: ev = '0;
      endcase
      chk(csr_rdata, ev, "rdata");
      chk(XLEN'(csr_illegal), XLEN'(r < 0), "illegal");
    end
    if (trap_valid) chk(handler_pc, ref_pc(), "handler_pc");
    @(posedge clk);
    c = ref_cause();
    if (csr_req && csr_we) begin
      r = decode(csr_addr, p);
      case (r)
        0: if (!(trap_valid && trap_priv == p[0])) m_cs[p] = csr_wdata;
        1: m_tv[p] = {csr_wdata[XLEN-1:2], (csr_wdata[1:0] == 2'b10) ? 2'b00 : csr_wdata[1:0]};
        2: m_iv[p] = csr_wdata & ~XLEN'(SCL - 1);
        3: m_ev[p] = csr_wdata & ~XLEN'(SCL - 1);
        default: ;
      endcase
    end
    if (trap_valid) m_cs[trap_priv] = c;
    @(negedge clk);
    csr_req = 0; csr_we = 0; trap_valid = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    csr_req = 1; csr_we = 1; csr_addr = a; csr_wdata = d; step();
  endtask

  task automatic rd(input logic [11:0] a);
    csr_req = 1; csr_we = 0; csr_addr = a; step();
  endtask

  task automatic set_trap(input logic pv, input logic irq, input logic ext,
                          input logic [15:0] mj, input logic [XLEN-18:0] mn,
                          input logic [XLEN-2:0] cd);
    trap_valid = 1; trap_priv = pv; trap_is_irq = irq; trap_is_ext = ext;
    trap_major = mj; trap_minor = mn; trap_code = cd;
  endtask

  function automatic logic [11:0] pick_addr(input int k);
    logic [11:0] t[10] = '{12'h342, 12'h305, 12'h307, 12'h308, 12'h142,
                           12'h105, 12'h107, 12'h108, 12'h300, 12'h343};
    return t[k % 10];
  endfunction

  initial begin
    repeat (CLK_P * 50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_tv[i] = 0; m_cs[i] = 0; m_iv[i] = 0; m_ev[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1"; // reset values
    for (int k = 0; k < 8; k++) rd(pick_addr(k));
    tag = "R3"; // unimplemented addresses: zero data, flag, write ignored
    rd(12'h300); wr(12'h300, 32'hFFFF_FFFF); wr(12'h343, 32'h1234_5678);
    for (int k = 0; k < 8; k++) rd(pick_addr(k));
    tag = "R2";
    wr(12'h305, 32'h8000_0003); rd(12'h305);
    tag = "R5";
    wr(12'h307, 32'h1000_0007); rd(12'h307);
    wr(12'h308, 32'h2000_0002); rd(12'h308);
    tag = "R9"; // table mode external: eivt + minor*4
    set_trap(1, 1, 1, 16'h000B, 15'd5, '0); step();
    tag = "R7"; rd(12'h342);
    tag = "R9"; set_trap(1, 1, 1, 16'hFFFF, '1, '0); step();
    tag = "R7"; rd(12'h342);
    tag = "R10"; set_trap(1, 1, 0, 16'h0033, 15'd9, 31'd7); step();
    tag = "R8"; rd(12'h342);
    tag = "R11"; set_trap(1, 0, 1, 16'h0044, 15'd3, 31'd2); step();
    tag = "R8"; rd(12'h342);
    tag = "R6"; rd(12'h142);
    tag = "R4"; // reserved mode maps to direct
    wr(12'h105, 32'h4000_0102); rd(12'h105);
    tag = "R11"; set_trap(0, 1, 1, 16'h0001, 15'd2, 31'd6); step();
    tag = "R8"; rd(12'h142);
    tag = "R4"; wr(12'h105, 32'h4000_0101); rd(12'h105);
    tag = "R11"; set_trap(0, 1, 0, '0, '0, 31'd5); step();
    set_trap(0, 1, 1, 16'h0009, 15'd1, 31'd3); step();
    tag = "R8"; rd(12'h142);
    tag = "R6"; // trap wins over a simultaneous cause write
    set_trap(1, 1, 0, '0, '0, 31'd11); csr_req = 1; csr_we = 1;
    csr_addr = 12'h342; csr_wdata = 32'hDEAD_BEEF; step();
    rd(12'h342);
    set_trap(0, 0, 0, '0, '0, 31'd4); csr_req = 1; csr_we = 1;
    csr_addr = 12'h342; csr_wdata = 32'h0000_00AA; step();
    rd(12'h342); rd(12'h142);
    tag = "R2"; // random mix
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom % 4;
      if (sel == 2 || sel == 3)
        set_trap(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                 15'($urandom), 31'($urandom % 64));
      if (sel != 2) begin
        csr_req = 1; csr_we = (sel != 0) && 1'($urandom); csr_addr = pick_addr($urandom % 10);
        csr_wdata = $urandom;
      end
      step();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule